// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR-style flash model and turns the stream of bus writes into device actions. Every accepted write (a one-cycle strobe with an address and a data byte) advances or resets a small sequence tracker. Short commands take three writes: two unlock writes followed by a command write. Erase-class commands take six writes: the three-write prefix ending in the extended-command byte 0x80, a second unlock pair, and a final command write.

The decoder raises one-cycle action pulses: chip erase, 4 KB sector erase, single-byte program and software write-protection release. Each pulse comes with the captured address and data. The decoder also holds the identification-mode flag. A static variant input selects between two device families. Variant 0 has sector erase and single-byte program. Variant 1 has protection release and an alternate identification entry. A command that the selected family lacks is dropped. The memory array, erase timing and read path sit outside this block.

Top module: `flash_cmd_decoder`

## Requirements
- R1: An unlock write matches only when wr_addr[14:0] is 0x5555 with data 0xAA (first of a pair), or 0x2AAA with data 0x55 (second of a pair). Higher address bits are ignored, and any other write at an unlock step returns the tracker to idle.
- R2: The third write must have wr_addr[14:0] = 0x5555, and its data byte is the command. A third write at any other address returns to idle with no action.
- R3: Third-write command 0x90 sets id_mode. Third-write command 0xF0 clears id_mode.
- R4: A write with data 0xF0 while the tracker is idle clears id_mode at any address, with no unlock writes.
- R5: Third-write command 0x80 performs no action. It requires a second unlock pair, and the sixth write then carries the final command. A write that breaks the second pair returns to idle.
- R6: Sixth-write command 0x10 at wr_addr[14:0] = 0x5555 pulses act_chip_erase in both variants.
- R7: With variant_sel = 0, sixth-write command 0x30 pulses act_sector_erase at any address, with act_addr equal to the sixth-write address and bits [11:0] cleared.
- R8: With variant_sel = 0, third-write command 0xA0 makes the next write pulse act_byte_prog, with act_addr and act_data equal to that write's address and data. The tracker then returns to idle.
- R9: With variant_sel = 1, sixth-write command 0x20 at 0x5555 pulses act_sdp_off, and sixth-write command 0x60 at 0x5555 sets id_mode.
- R10: A command that the selected variant lacks (0x30 or 0xA0 with variant 1; 0x20 or 0x60 with variant 0), or an unknown byte, gives no action and returns to idle.
- R11: After reset all outputs are 0. An action pulse lasts exactly one cycle and appears in the cycle after the write that completes the command. At most one action pulse is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| variant_sel | input | 1 | 0: sector erase / byte program family; 1: protection / alternate ID family |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8 | Write data |
| act_chip_erase | output | 1 | Chip erase pulse |
| act_sector_erase | output | 1 | Sector erase pulse |
| act_byte_prog | output | 1 | Byte program pulse |
| act_sdp_off | output | 1 | Write-protection release pulse |
| act_addr | output | ADDR_W | Address captured with the last action |
| act_data | output | 8 | Data captured with the last action |
| id_mode | output | 1 | Identification mode flag |

## Verification
A tracker stuck in the wrong step shows up only on a later write. For example, a lost unlock step makes the next command write miss its pulse or its id_mode change in the following cycle. A tracker that fails to return to idle makes a later unrelated write trigger an action. The bench compares every output on every cycle against a behavioural model, so a divergence is reported in the cycle after the write that exposes it. Broken sequences, commands invalid for the variant and the write after a byte program are aimed at exactly those hidden-state faults.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  typedef enum logic [2:0] {
    ST_PAIR1_A = 3'd0,
    ST_PAIR1_B = 3'd1,
    ST_CMD3    = 3'd2,
    ST_PAIR2_A = 3'd3,
    ST_PAIR2_B = 3'd4,
    ST_CMD6    = 3'd5,
    ST_PROG    = 3'd6
  } step_t;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_CHIP,
    ACT_SECTOR,
    ACT_PROG,
    ACT_SDP,
    ACT_ID_ON,
    ACT_ID_OFF
  } act_t;

  localparam logic [7:0] CMD_EXTENDED = 8'h80;
  localparam logic [7:0] CMD_ID_ON    = 8'h90;
  localparam logic [7:0] CMD_PROGRAM  = 8'hA0;
  localparam logic [7:0] CMD_ID_OFF   = 8'hF0;
  localparam logic [7:0] CMD_CHIP     = 8'h10;
  localparam logic [7:0] CMD_SECTOR   = 8'h30;
  localparam logic [7:0] CMD_SDP_OFF  = 8'h20;
  localparam logic [7:0] CMD_ID_ALT   = 8'h60;
endpackage

// File: rtl/fcd_unlock_match.sv
module fcd_unlock_match (
  input  logic [14:0] addr_lo,
  input  logic [7:0]  data,
  output logic        hit_first,
  output logic        hit_second,
  output logic        at_cmd_addr
);
  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

  always_comb begin
    at_cmd_addr = (addr_lo == KEY_ADDR_A);
    hit_first   = at_cmd_addr && (data == 8'hAA);
    hit_second  = (addr_lo == KEY_ADDR_B) && (data == 8'h55);
  end
endmodule

// File: rtl/fcd_cmd_decode.sv
module fcd_cmd_decode
  import fcd_pkg::*;
(
  input  step_t      cur,
  input  logic       variant_sel,
  input  logic       hit_first,
  input  logic       hit_second,
  input  logic       at_cmd_addr,
  input  logic [7:0] data,
  output step_t      nxt,
  output act_t       act
);
  always_comb begin
    nxt = ST_PAIR1_A;
    act = ACT_NONE;
    unique case (cur)
      ST_PAIR1_A: begin
        if (data == CMD_ID_OFF) act = ACT_ID_OFF;
        else if (hit_first)     nxt = ST_PAIR1_B;
      end
      ST_PAIR2_A: if (hit_first)  nxt = ST_PAIR2_B;
      ST_PAIR1_B: if (hit_second) nxt = ST_CMD3;
      ST_PAIR2_B: if (hit_second) nxt = ST_CMD6;
      ST_CMD3: begin
        if (at_cmd_addr) begin
          case (data)
            CMD_EXTENDED: nxt = ST_PAIR2_A;
            CMD_ID_ON:    act = ACT_ID_ON;
            CMD_ID_OFF:   act = ACT_ID_OFF;
            CMD_PROGRAM:  if (!variant_sel) nxt = ST_PROG;
            default:      ;
          endcase
        end
      end
      ST_CMD6: begin
        if (!variant_sel && data == CMD_SECTOR) act = ACT_SECTOR;
        else if (at_cmd_addr) begin
          case (data)
            CMD_CHIP:    act = ACT_CHIP;
            CMD_SDP_OFF: if (variant_sel) act = ACT_SDP;
            CMD_ID_ALT:  if (variant_sel) act = ACT_ID_ON;
            default:     ;
          endcase
        end
      end
      ST_PROG: act = ACT_PROG;
      default: ;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SECTOR_LG2 = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              variant_sel,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              act_chip_erase,
  output logic              act_sector_erase,
  output logic              act_byte_prog,
  output logic              act_sdp_off,
  output logic [ADDR_W-1:0] act_addr,
  output logic [7:0]        act_data,
  output logic              id_mode
);
  localparam logic [ADDR_W-1:0] SECTOR_MASK = ~((ADDR_W'(1) << SECTOR_LG2) - ADDR_W'(1));

  step_t step_q, step_d;
  act_t  act_d;
  logic  hit_first, hit_second, at_cmd_addr;

  fcd_unlock_match u_match (
    .addr_lo    (wr_addr[14:0]),
    .data       (wr_data),
    .hit_first  (hit_first),
    .hit_second (hit_second),
    .at_cmd_addr(at_cmd_addr)
  );

  fcd_cmd_decode u_decode (
    .cur        (step_q),
    .variant_sel(variant_sel),
    .hit_first  (hit_first),
    .hit_second (hit_second),
    .at_cmd_addr(at_cmd_addr),
    .data       (wr_data),
    .nxt        (step_d),
    .act        (act_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q           <= ST_PAIR1_A;
      id_mode          <= 1'b0;
      act_chip_erase   <= 1'b0;
      act_sector_erase <= 1'b0;
      act_byte_prog    <= 1'b0;
      act_sdp_off      <= 1'b0;
      act_addr         <= '0;
      act_data         <= '0;
    end else begin
      act_chip_erase   <= wr_en && (act_d == ACT_CHIP);
      act_sector_erase <= wr_en && (act_d == ACT_SECTOR);
      act_byte_prog    <= wr_en && (act_d == ACT_PROG);
      act_sdp_off      <= wr_en && (act_d == ACT_SDP);
      if (wr_en) begin
        step_q <= step_d;
        if (act_d == ACT_ID_ON)  id_mode <= 1'b1;
        if (act_d == ACT_ID_OFF) id_mode <= 1'b0;
        if (act_d inside {ACT_CHIP, ACT_SECTOR, ACT_PROG, ACT_SDP}) begin
          act_addr <= (act_d == ACT_SECTOR) ? (wr_addr & SECTOR_MASK) : wr_addr;
          act_data <= wr_data;
        end
      end
    end
  end

  p_one_action_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_chip_erase, act_sector_erase, act_byte_prog, act_sdp_off}));

  p_pulse_short_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_chip_erase || act_sector_erase || act_byte_prog || act_sdp_off)
      |=> !(act_chip_erase || act_sector_erase || act_byte_prog || act_sdp_off));

  p_action_needs_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_chip_erase || act_sector_erase || act_byte_prog || act_sdp_off)
      |-> $past(wr_en));

  p_sector_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
    act_sector_erase |-> (act_addr[SECTOR_LG2-1:0] == '0));

  p_sector_variant_r10: assert property (@(posedge clk) disable iff (!rst_n)
    act_sector_erase |-> !$past(variant_sel));

  p_prog_variant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    act_byte_prog |-> !$past(variant_sel));

  p_sdp_variant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    act_sdp_off |-> $past(variant_sel));

  p_id_change_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(id_mode) || $fell(id_mode)) |-> $past(wr_en));
endmodule

// File: tb/flash_cmd_decoder_tb.sv
module flash_cmd_decoder_tb;
  localparam int AW = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic variant_sel = 1'b0;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic act_chip_erase, act_sector_erase, act_byte_prog, act_sdp_off, id_mode;
  logic [AW-1:0] act_addr;
  logic [7:0] act_data;

  always #5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .SECTOR_LG2(12)) u_dut (
    .clk(clk), .rst_n(rst_n), .variant_sel(variant_sel), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .act_chip_erase(act_chip_erase), .act_sector_erase(act_sector_erase),
    .act_byte_prog(act_byte_prog), .act_sdp_off(act_sdp_off),
    .act_addr(act_addr), .act_data(act_data), .id_mode(id_mode)
  );

  int checks = 0;
  int errors = 0;
  string cur_req = "R11";
  bit done = 0;

  // behavioural reference: integer step counter, 6 = waiting for program data
  int m_step = 0;
  bit m_chip = 0, m_sect = 0, m_prog = 0, m_sdp = 0, m_id = 0;
  logic [AW-1:0] m_addr = '0;
  logic [7:0] m_data = '0;

  always @(posedge clk) begin
    bit c, s, p, d;
    int lo;
    c = 0; s = 0; p = 0; d = 0;
    lo = int'(wr_addr[14:0]);
    if (!rst_n) begin
      m_step = 0; m_id = 0; m_addr = '0; m_data = '0;
    end else if (wr_en) begin
      int ns;
      ns = 0;
      if (m_step == 0) begin
        if (wr_data == 8'hF0) m_id = 0;
        else if (lo == 'h5555 && wr_data == 8'hAA) ns = 1;
      end else if (m_step == 3) begin
        if (lo == 'h5555 && wr_data == 8'hAA) ns = 4;
      end else if (m_step == 1 || m_step == 4) begin
        if (lo == 'h2AAA && wr_data == 8'h55) ns = m_step + 1;
      end else if (m_step == 2) begin
        if (lo == 'h5555) begin
          if (wr_data == 8'h80) ns = 3;
          if (wr_data == 8'h90) m_id = 1;
          if (wr_data == 8'hF0) m_id = 0;
          if (wr_data == 8'hA0 && !variant_sel) ns = 6;
        end
      end else if (m_step == 5) begin
        if (!variant_sel && wr_data == 8'h30) s = 1;
        else if (lo == 'h5555) begin
          if (wr_data == 8'h10) c = 1;
          if (variant_sel && wr_data == 8'h20) d = 1;
          if (variant_sel && wr_data == 8'h60) m_id = 1;
        end
      end else if (m_step == 6) begin
        p = 1;
      end
      m_step = ns;
      if (c || s || p || d) begin
        m_addr = s ? {wr_addr[AW-1:12], 12'h000} : wr_addr;
        m_data = wr_data;
      end
    end
    m_chip = c; m_sect = s; m_prog = p; m_sdp = d;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // every-cycle comparison against the model, away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      check(cur_req, "chip", act_chip_erase, m_chip);
      check(cur_req, "sector", act_sector_erase, m_sect);
      check(cur_req, "prog", act_byte_prog, m_prog);
      check(cur_req, "sdp", act_sdp_off, m_sdp);
      check(cur_req, "id", id_mode, m_id);
      check(cur_req, "addr", act_addr, m_addr);
      check(cur_req, "data", act_data, m_data);
    end
  end

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic unlock(input logic [AW-1:0] hi);
    wr(hi | 20'h05555, 8'hAA);
    wr(hi | 20'h02AAA, 8'h55);
  endtask

  task automatic cmd3(input logic [7:0] d);
    unlock(20'h0);
    wr(20'h05555, d);
  endtask

  task automatic cmd6(input logic [AW-1:0] a, input logic [7:0] d);
    cmd3(8'h80);
    unlock(20'h0);
    wr(a, d);
  endtask

  function automatic int any_act();
    return int'(act_chip_erase) + int'(act_sector_erase) + int'(act_byte_prog) + int'(act_sdp_off);
  endfunction

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        errors++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R11";
    check("R11", "reset id", id_mode, 0);
    check("R11", "reset acts", any_act(), 0);
    check("R11", "reset addr", act_addr, 0);
    rst_n = 1;
    @(negedge clk);

    cur_req = "R1";
    unlock(20'hF0000); wr(20'hA5555, 8'h90);
    check("R1", "upper addr bits ignored", id_mode, 1);
    cur_req = "R4";
    wr(20'h12345, 8'hF0);
    check("R4", "bare F0 exits", id_mode, 0);
    cur_req = "R3";
    cmd3(8'h90);
    check("R3", "enter id", id_mode, 1);
    cmd3(8'hF0);
    check("R3", "exit id", id_mode, 0);

    cur_req = "R6";
    cmd6(20'h05555, 8'h10);
    check("R6", "chip erase", act_chip_erase, 1);
    @(negedge clk);
    check("R11", "pulse one cycle", act_chip_erase, 0);

    cur_req = "R7";
    cmd6(20'h3ABCD, 8'h30);
    check("R7", "sector erase", act_sector_erase, 1);
    check("R7", "sector addr", act_addr, 20'h3A000);

    cur_req = "R8";
    cmd3(8'hA0);
    wr(20'h12345, 8'h5A);
    check("R8", "prog pulse", act_byte_prog, 1);
    check("R8", "prog addr", act_addr, 20'h12345);
    check("R8", "prog data", act_data, 8'h5A);
    wr(20'h12346, 8'h77);
    check("R8", "back to idle", act_byte_prog, 0);

    cur_req = "R1";
    wr(20'h05555, 8'hAA); wr(20'h02AAB, 8'h55); wr(20'h05555, 8'h90);
    check("R1", "bad second addr", id_mode, 0);
    wr(20'h05555, 8'hAB); wr(20'h02AAA, 8'h55); wr(20'h05555, 8'h90);
    check("R1", "bad first data", id_mode, 0);
    cur_req = "R2";
    unlock(20'h0); wr(20'h05554, 8'h90);
    check("R2", "bad cmd addr", id_mode, 0);

    cur_req = "R5";
    cmd3(8'h80);
    check("R5", "0x80 no action", any_act(), 0);
    wr(20'h05555, 8'h10);
    check("R5", "no second pair", act_chip_erase, 0);
    cmd3(8'h80); wr(20'h05555, 8'hAA); wr(20'h02AAA, 8'h54); wr(20'h05555, 8'h10);
    check("R5", "broken second pair", act_chip_erase, 0);

    cur_req = "R10";
    cmd6(20'h05555, 8'h20);
    check("R10", "sdp in variant 0", act_sdp_off, 0);
    cmd6(20'h05555, 8'h60);
    check("R10", "alt id in variant 0", id_mode, 0);

    variant_sel = 1;
    cur_req = "R9";
    cmd6(20'h45555, 8'h20);
    check("R9", "sdp off", act_sdp_off, 1);
    check("R9", "sdp addr", act_addr, 20'h45555);
    cmd6(20'h05555, 8'h60);
    check("R9", "alt id on", id_mode, 1);
    wr(20'h00000, 8'hF0);
    cur_req = "R6";
    cmd6(20'h05555, 8'h10);
    check("R6", "chip erase variant 1", act_chip_erase, 1);
    cur_req = "R10";
    cmd6(20'h3ABCD, 8'h30);
    check("R10", "sector in variant 1", act_sector_erase, 0);
    cmd3(8'hA0);
    wr(20'h12345, 8'h5A);
    check("R10", "prog in variant 1", act_byte_prog, 0);
    cmd6(20'h05555, 8'h77);
    check("R10", "unknown code", any_act(), 0);
    cmd3(8'h90);
    check("R10", "idle after unknown", id_mode, 1);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule